// File: doc/BRIEF.md
# Tile Row Integer-to-Float Extractor

This block takes one row from a matrix tile held as 16 rows of 64 bytes and returns a 512-bit vector of sixteen 32-bit lanes. Each lane holds a signed 32-bit integer from the row, converted to a single-precision float. A 32-bit selector word names the row and a 64-byte chunk of that row. The block is also given the configured row width in bytes and the configured number of rows. Any lane that falls past the configured width is forced to zero. A request for a row that is not configured returns a vector of zeros.

Requests arrive on a valid/ready pair. The block has two states. `ST_IDLE` raises `req_ready`. The transition `accept` fires on `req_valid` in `ST_IDLE`: it captures the converted vector and moves to `ST_HOLD`. `ST_HOLD` raises `resp_valid` and holds the vector. The transition `drain` fires on `resp_ready` in `ST_HOLD` and returns to `ST_IDLE`. Conversion always uses round-to-nearest-even and sets no exception flags.

Top module: `tile_row_i2f`

## Requirements
- R1: The selector bits [15:0] are the row index and bits [31:16] are the chunk number. With the chunk number c, output lane i (bits [32i+31:32i]) comes from dword c*16+i of the selected row. Dword j of row r sits at `tile_data[r*512 + 32j +: 32]`.
- R2: Lane i is zero when c*16+i is at or above floor(row_bytes/4). A row_bytes value that is not a multiple of 4 therefore drops the partial dword.
- R3: Any nonzero chunk number gives an all-zero vector, because a row is only 64 bytes wide.
- R4: A row index at or above row_count gives an all-zero vector.
- R5: An integer whose magnitude is at most 2^24 converts exactly. An integer 0 converts to +0.0 (0x00000000), and every nonzero result keeps the sign of its input.
- R6: A larger magnitude is rounded to a 24-bit significand using round-to-nearest-even. For example, 16777217 gives 0x4B800000 and 16777219 gives 0x4B800002.
- R7: -2147483648 converts exactly to 0xCF000000.
- R8: The `accept` transition happens only when req_valid and req_ready are both high. resp_valid goes high on the next clock edge, and req_ready is low while resp_valid is high.
- R9: While resp_valid is high and resp_ready is low, resp_valid and resp_data stay unchanged. After the `drain` transition, resp_valid is low.
- R10: After reset, resp_valid is 0, req_ready is 1 and resp_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| sel | input | 32 | Row index in [15:0], chunk number in [31:16] |
| row_bytes | input | 7 | Configured row width in bytes (0 to 64) |
| row_count | input | 5 | Configured number of rows (0 to 16) |
| tile_data | input | 8192 | Tile storage, row r at bits [512r +: 512] |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_data | output | 512 | Sixteen fp32 lanes, lane i at bits [32i +: 32] |

## Verification
On every cycle the assertions check the following:
- the handshake sequencing and that the result holds while the consumer stalls;
- that an out-of-range row or a nonzero chunk gives an all-zero result;
- inside each lane converter, that a zero input maps to +0.0 and that the sign is kept.

The numeric value of each converted lane, the rounding of ties and the choice of dword per lane cannot be checked cycle by cycle. The directed scenarios show them by comparing every lane against an arithmetic model of the conversion.

// File: rtl/tile_row_i2f_pkg.sv
package tile_row_i2f_pkg;
    parameter int TILE_ROWS  = 16;
    parameter int ROW_BYTES  = 64;
    parameter int VEC_BYTES  = 64;
    localparam int LANES     = VEC_BYTES / 4;
    localparam int ROW_DW    = ROW_BYTES / 4;
    localparam int ROW_BITS  = ROW_BYTES * 8;
    localparam int VEC_BITS  = VEC_BYTES * 8;
    localparam int ROW_IDX_W = $clog2(TILE_ROWS);
    localparam int DW_IDX_W  = $clog2(ROW_DW);
    localparam int WIDTH_W   = $clog2(ROW_BYTES + 1);
    localparam int COUNT_W   = $clog2(TILE_ROWS + 1);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/tile_row_sel_decode.sv
module tile_row_sel_decode
    import tile_row_i2f_pkg::*;
(
    input  logic [31:0]           sel,
    input  logic [WIDTH_W-1:0]    row_bytes,
    input  logic [COUNT_W-1:0]    row_count,
    output logic [ROW_IDX_W-1:0]  row_idx,
    output logic [DW_IDX_W-1:0]   dw_base,
    output logic [LANES-1:0]      lane_en
);
    logic [15:0] row_field;
    logic [15:0] chunk_field;
    logic        row_ok;
    logic [31:0] dw_limit;
    logic [31:0] first_dw;

    always_comb begin
        row_field   = sel[15:0];
        chunk_field = sel[31:16];
        row_ok      = {16'd0, row_field} < {{(32-COUNT_W){1'b0}}, row_count};
        row_idx     = row_field[ROW_IDX_W-1:0];
        dw_limit    = {{(32-WIDTH_W){1'b0}}, row_bytes} >> 2;
        first_dw    = {16'd0, chunk_field} * LANES;
        dw_base     = first_dw[DW_IDX_W-1:0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_mask
        assign lane_en[i] = row_ok && ((first_dw + i) < dw_limit);
    end
endmodule

// File: rtl/tile_row_i2f_lane.sv
module tile_row_i2f_lane (
    input  logic [31:0] int_in,
    output logic [31:0] fp_out
);
    logic        neg;
    logic [31:0] mag;
    logic [4:0]  lead;
    logic [31:0] norm;
    logic        guard_bit;
    logic        sticky_bit;
    logic        round_up;
    logic [24:0] sig_rnd;
    logic [7:0]  expo;

    always_comb begin
        neg  = int_in[31];
        mag  = neg ? (~int_in + 32'd1) : int_in;
        lead = '0;
        for (int b = 0; b < 32; b++) begin
            if (mag[b]) lead = 5'(b);
        end
        norm       = mag << (5'd31 - lead);
        guard_bit  = norm[7];
        sticky_bit = |norm[6:0];
        round_up   = guard_bit && (sticky_bit || norm[8]);
        sig_rnd    = {1'b0, norm[31:8]} + {24'd0, round_up};
        expo       = 8'd127 + {3'd0, lead} + {7'd0, sig_rnd[24]};
        if (mag == '0) begin
            fp_out = '0;
        end else begin
            fp_out = {neg, expo, sig_rnd[24] ? 23'd0 : sig_rnd[22:0]};
        end
    end

    always_comb begin
        if (int_in == '0) begin
            AST_ZERO_TO_POS_ZERO: assert (fp_out == '0); // R5
        end
        if (int_in != '0) begin
            AST_SIGN_KEPT: assert (fp_out[31] == int_in[31]); // R5
        end
    end
endmodule

// File: rtl/tile_row_i2f.sv
module tile_row_i2f
    import tile_row_i2f_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [31:0]                 sel,
    input  logic [6:0]                  row_bytes,
    input  logic [4:0]                  row_count,
    input  logic [TILE_ROWS*ROW_BITS-1:0] tile_data,
    output logic                        resp_valid,
    input  logic                        resp_ready,
    output logic [VEC_BITS-1:0]         resp_data
);
    xfer_state_e state_q, state_d;

    logic [ROW_IDX_W-1:0] row_idx;
    logic [DW_IDX_W-1:0]  dw_base;
    logic [LANES-1:0]     lane_en;
    logic [ROW_BITS-1:0]  row_vec;
    logic [VEC_BITS-1:0]  conv_vec;
    logic                 accept;

    tile_row_sel_decode u_decode (
        .sel       (sel),
        .row_bytes (row_bytes[WIDTH_W-1:0]),
        .row_count (row_count[COUNT_W-1:0]),
        .row_idx   (row_idx),
        .dw_base   (dw_base),
        .lane_en   (lane_en)
    );

    assign row_vec = tile_data[row_idx*ROW_BITS +: ROW_BITS];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DW_IDX_W-1:0] src_dw;
        logic [31:0]         fp_lane;
        assign src_dw = dw_base + DW_IDX_W'(i);
        tile_row_i2f_lane u_cvt (
            .int_in (row_vec[src_dw*32 +: 32]),
            .fp_out (fp_lane)
        );
        assign conv_vec[i*32 +: 32] = lane_en[i] ? fp_lane : 32'd0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept (IDLE->HOLD), drain (HOLD->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_HOLD;
            ST_HOLD: if (resp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_HOLD: resp_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      resp_data <= '0;
        else if (accept) resp_data <= conv_vec;
    end

    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid); // R8
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && resp_valid)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data))); // R9
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready) |=> !resp_valid); // R9
    AST_ROW_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ({16'd0, sel[15:0]} >= {27'd0, row_count})) |=> (resp_data == '0)); // R4

    if (ROW_BYTES == VEC_BYTES) begin : g_chunk_chk
        AST_CHUNK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && (sel[31:16] != 16'd0)) |=> (resp_data == '0)); // R3
    end
endmodule

// File: tb/test_tile_row_i2f.sv
module test_tile_row_i2f;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   sel = '0;
    logic [6:0]    row_bytes = 7'd64;
    logic [4:0]    row_count = 5'd16;
    logic [8191:0] tile_data;
    logic          resp_valid;
    logic          resp_ready = 1'b0;
    logic [511:0]  resp_data;

    logic [31:0] tmem [16][16];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int r = 0; r < 16; r++)
            for (int j = 0; j < 16; j++)
                tile_data[r*512 + j*32 +: 32] = tmem[r][j];
    end

    tile_row_i2f i_tile_row_i2f (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .sel(sel), .row_bytes(row_bytes), .row_count(row_count), .tile_data(tile_data),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data)
    );

    function automatic logic [31:0] ref_i2f(logic [31:0] x);
        longint m, q, rem, half;
        int e, sh;
        logic s;
        if (x == 0) return 32'd0;
        s = x[31];
        m = s ? -longint'($signed(x)) : longint'(x);
        e = 0;
        while ((m >> (e + 1)) != 0) e++;
        if (e <= 23) begin
            q = m << (23 - e);
        end else begin
            sh = e - 23;
            q = m >> sh;
            rem = m - (q << sh);
            half = longint'(1) << (sh - 1);
            if (rem > half || (rem == half && q[0])) q++;
            if (q == (longint'(1) << 24)) begin q = q >> 1; e++; end
        end
        return {s, 8'(e + 127), q[22:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one request, wait for result, check all lanes against the model
    task automatic run_req(string req, logic [31:0] s);
        logic [31:0] lane_exp;
        int chunk, row;
        @(negedge clk);
        check({req, " req_ready"}, 32'(req_ready), 32'd1);
        sel = s; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " resp_valid"}, 32'(resp_valid), 32'd1);
        row = int'(s[15:0]); chunk = int'(s[31:16]);
        for (int i = 0; i < 16; i++) begin
            if (row >= int'(row_count) || chunk != 0 || i >= int'(row_bytes) / 4)
                lane_exp = 32'd0;
            else
                lane_exp = ref_i2f(tmem[row][i]);
            check(req, resp_data[i*32 +: 32], lane_exp);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check({req, " drain"}, 32'(resp_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R10 resp_valid", 32'(resp_valid), 32'd0);
        check("R10 req_ready", 32'(req_ready), 32'd1);
        check("R10 resp_data", 32'(resp_data != '0), 32'd0);
    endtask

    task automatic t_select();
        for (int i = 0; i < 16; i++) tmem[5][i] = 32'(i * 3 - 20);
        run_req("R1 row5", 32'h0000_0005);
        run_req("R1 row0", 32'h0000_0000);
    endtask

    task automatic t_width();
        row_bytes = 7'd20; run_req("R2 width20", 32'd2);
        row_bytes = 7'd23; run_req("R2 width23", 32'd2);
        row_bytes = 7'd0;  run_req("R2 width0", 32'd2);
        row_bytes = 7'd64;
    endtask

    task automatic t_chunk();
        run_req("R3 chunk1", 32'h0001_0002);
        run_req("R3 chunkFFFF", 32'hFFFF_0003);
    endtask

    task automatic t_row_oor();
        row_count = 5'd8;
        run_req("R4 row8", 32'd8);
        run_req("R4 row7", 32'd7);
        row_count = 5'd16;
        run_req("R4 row_hi", 32'h0000_0100);
    endtask

    task automatic t_exact();
        tmem[9][0] = 32'd0;          tmem[9][1] = 32'd1;
        tmem[9][2] = 32'hFFFF_FFFF;  tmem[9][3] = 32'd16777216;
        tmem[9][4] = -32'sd16777216; tmem[9][5] = 32'd12345;
        run_req("R5 exact", 32'd9);
        check("R5 one", ref_i2f(32'd1), 32'h3F80_0000);
        check("R5 minus one", ref_i2f(32'hFFFF_FFFF), 32'hBF80_0000);
    endtask

    task automatic t_round();
        tmem[10][0] = 32'd16777217; tmem[10][1] = 32'd16777219;
        tmem[10][2] = 32'h7FFF_FFFF; tmem[10][3] = 32'd33554435;
        tmem[10][4] = -32'sd16777217; tmem[10][5] = 32'h1234_5678;
        run_req("R6 round", 32'd10);
        check("R6 tie even", ref_i2f(32'd16777217), 32'h4B80_0000);
        check("R6 tie up", ref_i2f(32'd16777219), 32'h4B80_0002);
        check("R6 max", ref_i2f(32'h7FFF_FFFF), 32'h4F00_0000);
    endtask

    task automatic t_min();
        tmem[11][0] = 32'h8000_0000;
        @(negedge clk);
        sel = 32'd11; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 int min", resp_data[31:0], 32'hCF00_0000);
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
    endtask

    task automatic t_hold();
        logic [511:0] first;
        @(negedge clk);
        sel = 32'd5; req_valid = 1'b1;
        @(negedge clk);
        sel = 32'd9;  // still valid; must not be accepted while holding
        first = resp_data;
        check("R8 valid after accept", 32'(resp_valid), 32'd1);
        check("R8 ready low in hold", 32'(req_ready), 32'd0);
        repeat (4) @(negedge clk);
        check("R9 valid held", 32'(resp_valid), 32'd1);
        check("R9 data held", 32'(resp_data == first), 32'd1);
        req_valid = 1'b0;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check("R9 drained", 32'(resp_valid), 32'd0);
        check("R8 ready after drain", 32'(req_ready), 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        for (int r = 0; r < 16; r++)
            for (int j = 0; j < 16; j++)
                tmem[r][j] = 32'(r * 1000 + j * 7 - 50);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_select();
        t_width();
        t_chunk();
        t_row_oor();
        t_exact();
        t_round();
        t_min();
        t_hold();
        finish_run();
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule